// File: doc/BRIEF.md
# Complementary PWM Deadtime Generator

This block turns one raw PWM waveform per channel pair into two complementary gate drives, an even channel and an odd channel. When the deadtime is active, both drives are held inactive for a programmed number of clocks each time the raw waveform changes level. The side that is switching off falls at once. The side that is switching on rises only after the gap. This keeps a half bridge from conducting through both switches at the same time.

All pairs share one configuration: an enable, a 6-bit gap length and a 2-bit prescale select. The gap lasts `dt_val` prescaled clock periods. Each pair runs its own timer, so pairs switch independently. A per-channel polarity bit is applied last, so the gap is always defined in terms of the active state. When the enable is low or the gap length is zero, the odd channel is the plain complement of the even channel.

Top module: `dt_complement`

## Requirements
- R1: While reset is asserted, and until the first gap after reset has run out, every output pin sits at its inactive level (the pin equals its polarity bit).
- R2: If `dt_en`=0 or `dt_val`=0, the even channel follows the raw input one clock later and the odd channel is its complement, with no gap.
- R3: If `dt_en`=1 and `dt_val`≠0, a level change on the raw input makes both channels inactive from the next clock. The side being turned on becomes active exactly D clocks after that, where D = `dt_val` × division.
- R4: The side being turned off goes inactive on the first clock after the raw input changes.
- R5: The prescale select `dt_ps` sets the division as follows: 00 gives 1, 01 gives 1, 10 gives 4 and 11 gives 16.
- R6: The two channels of a pair are never active in the same cycle.
- R7: If the raw input changes again before a gap has finished, the pending turn-on is cancelled and a fresh full gap starts for the other side. A pulse shorter than the gap therefore never appears.
- R8: A polarity bit of 1 makes that pin active-low. Polarity is applied after deadtime insertion and does not change the gap timing.
- R9: `dt_val` and `dt_ps` are captured when a gap starts. A change during a gap takes effect from the next gap.
- R10: One configuration serves all pairs, and each pair times its own gaps from its own raw input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dt_en | input | 1 | Deadtime enable |
| dt_ps | input | 2 | Prescale select (00/01 ÷1, 10 ÷4, 11 ÷16) |
| dt_val | input | CNT_W | Gap length in prescaled clocks |
| pwm_raw | input | NPAIR | Raw PWM per pair; 1 asks for the even side to be active |
| pol_even | input | NPAIR | Polarity of the even channels; 1 means active-low |
| pol_odd | input | NPAIR | Polarity of the odd channels; 1 means active-low |
| ch_even | output | NPAIR | Even channel pins |
| ch_odd | output | NPAIR | Odd channel pins |

## Verification
The bench builds the block with its defaults, NPAIR=2 and CNT_W=6. This covers every prescale code together with gap lengths from 1 up to the maximum of 63, which is 1008 clocks at ÷16. Both pairs run side by side, which shows that they share the setting and switch independently. Mixed polarity settings, a pulse shorter than the gap, and a setting change in the middle of a gap are all exercised against gap lengths the bench computes itself.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int PRE_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ON_E,
    ST_ON_O,
    ST_WAIT_E,
    ST_WAIT_O
  } pair_st_e;

  // prescale division minus one for a select code
  function automatic logic [PRE_W-1:0] ps_div_m1(input logic [1:0] ps);
    case (ps)
      2'b10:   return PRE_W'(3);
      2'b11:   return PRE_W'(15);
      default: return PRE_W'(0);
    endcase
  endfunction

  // gap length in system clocks
  function automatic int dt_cycles(input int val, input logic [1:0] ps);
    return val * (int'(ps_div_m1(ps)) + 1);
  endfunction
endpackage

// File: rtl/dt_timer.sv
module dt_timer
  import dt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] val,
  input  logic [1:0]       ps,
  output logic             done
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] divm1_q;
  logic [CNT_W-1:0] tick_q;
  logic             run_q;
  logic             pre_wrap;

  assign pre_wrap = (pre_q == '0);
  assign done     = run_q && pre_wrap && (tick_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      divm1_q <= '0;
      tick_q  <= '0;
      run_q   <= 1'b0;
    end else if (start) begin
      run_q   <= 1'b1;
      divm1_q <= ps_div_m1(ps);
      pre_q   <= ps_div_m1(ps);
      tick_q  <= val;
    end else if (run_q) begin
      if (done) begin
        run_q <= 1'b0;
      end else if (pre_wrap) begin
        pre_q  <= divm1_q;
        tick_q <= tick_q - CNT_W'(1);
      end else begin
        pre_q <= pre_q - PRE_W'(1);
      end
    end
  end

  // a running timer never reaches a zero tick count
  assert_tick_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tick_q != '0));
  // a gap is started only with a non-zero length
  assert_start_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (val != '0));
endmodule

// File: rtl/dt_pair.sv
module dt_pair
  import dt_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dt_on,
  input  logic [CNT_W-1:0] dt_val,
  input  logic [1:0]       dt_ps,
  input  logic             pwm,
  input  logic             pol_e,
  input  logic             pol_o,
  output logic             ch_e,
  output logic             ch_o
);
  localparam int GAP_W = CNT_W + PRE_W + 1;

  pair_st_e st_q, st_d;
  logic     raw_q;
  logic     start;
  logic     tm_done;
  logic     act_e, act_o;
  logic     lvl_change;

  assign lvl_change = (pwm != raw_q);

  dt_timer #(.CNT_W(CNT_W)) u_tm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .val   (dt_val),
    .ps    (dt_ps),
    .done  (tm_done)
  );

  always_comb begin
    st_d  = st_q;
    start = 1'b0;
    if (!dt_on) begin
      st_d = pwm ? ST_ON_E : ST_ON_O;
    end else if (st_q == ST_IDLE || lvl_change) begin
      start = 1'b1;
      st_d  = pwm ? ST_WAIT_E : ST_WAIT_O;
    end else if (tm_done && st_q == ST_WAIT_E) begin
      st_d = ST_ON_E;
    end else if (tm_done && st_q == ST_WAIT_O) begin
      st_d = ST_ON_O;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      raw_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      raw_q <= pwm;
    end
  end

  assign act_e = (st_q == ST_ON_E);
  assign act_o = (st_q == ST_ON_O);
  assign ch_e  = act_e ^ pol_e;
  assign ch_o  = act_o ^ pol_o;

  // gap observer for the assertions: clocks with both sides inactive
  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] dly_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0;
      dly_q <= '0;
    end else if (start) begin
      gap_q <= '0;
      dly_q <= GAP_W'(dt_cycles(int'(dt_val), dt_ps));
    end else if (!act_e && !act_o) begin
      if (gap_q != '1) gap_q <= gap_q + GAP_W'(1);
    end else begin
      gap_q <= '0;
    end
  end

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !((ch_e ^ pol_e) && (ch_o ^ pol_o)));
  assert_fall_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_e && !pwm) |=> !act_e);
  assert_fall_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && pwm) |=> !act_o);
  assert_plain_cmp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dt_on |=> (act_e == $past(pwm)) && (act_o == !$past(pwm)));
  assert_gap_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(act_e) && $past(st_q) == ST_WAIT_E) |-> (gap_q == dly_q));
  assert_gap_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(act_o) && $past(st_q) == ST_WAIT_O) |-> (gap_q == dly_q));
  assert_swallow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT_E && dt_on && !pwm) |=> !act_e);
endmodule

// File: rtl/dt_complement.sv
module dt_complement
  import dt_pkg::*;
#(
  parameter int NPAIR = 2,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dt_en,
  input  logic [1:0]       dt_ps,
  input  logic [CNT_W-1:0] dt_val,
  input  logic [NPAIR-1:0] pwm_raw,
  input  logic [NPAIR-1:0] pol_even,
  input  logic [NPAIR-1:0] pol_odd,
  output logic [NPAIR-1:0] ch_even,
  output logic [NPAIR-1:0] ch_odd
);
  logic dt_on;
  assign dt_on = dt_en && (dt_val != '0);

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    dt_pair #(.CNT_W(CNT_W)) u_pair (
      .clk    (clk),
      .rst_n  (rst_n),
      .dt_on  (dt_on),
      .dt_val (dt_val),
      .dt_ps  (dt_ps),
      .pwm    (pwm_raw[p]),
      .pol_e  (pol_even[p]),
      .pol_o  (pol_odd[p]),
      .ch_e   (ch_even[p]),
      .ch_o   (ch_odd[p])
    );
  end

  // R1: inactive pins throughout reset
  always_comb begin
    if (!rst_n) begin
      assert_rst_idle_R1: assert ((ch_even == pol_even) && (ch_odd == pol_odd));
    end
  end
endmodule

// File: tb/sim_dt_complement.sv
module sim_dt_complement;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dt_en = 1'b0;
  logic [1:0]    dt_ps = '0;
  logic [CW-1:0] dt_val = '0;
  logic [NP-1:0] pwm = '0;
  logic [NP-1:0] pol_e = '0;
  logic [NP-1:0] pol_o = '0;
  logic [NP-1:0] ch_e, ch_o;

  int total = 0;
  int bad = 0;
  int overlap = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dt_complement #(.NPAIR(NP), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .dt_en(dt_en), .dt_ps(dt_ps), .dt_val(dt_val),
    .pwm_raw(pwm), .pol_even(pol_e), .pol_odd(pol_o),
    .ch_even(ch_e), .ch_odd(ch_o)
  );

  function automatic int exp_gap(bit en, int val, int ps);
    if (!en || val == 0) return 0;
    if (ps == 2) return val * 4;
    if (ps == 3) return val * 16;
    return val;
  endfunction

  function automatic bit act_e(int p);
    return ch_e[p] ^ pol_e[p];
  endfunction
  function automatic bit act_o(int p);
    return ch_o[p] ^ pol_o[p];
  endfunction

  task automatic chk(bit ok, string req, string what, int actual, int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        if (act_e(p) && act_o(p)) overlap++;
      end
    end
  end

  task automatic set_cfg(bit en, int val, int ps);
    @(posedge clk);
    #1;
    dt_en  = en;
    dt_val = CW'(val);
    dt_ps  = 2'(ps);
  endtask

  // drive both raw inputs to lvl, measure the gap on every pair
  task automatic edge_run(bit lvl, int expg, string req, int late_val);
    int  gap [NP];
    bit  seen [NP];
    bit  loser_off;
    bit  won, lost;
    loser_off = 1'b1;
    for (int p = 0; p < NP; p++) begin
      gap[p] = 0;
      seen[p] = 1'b0;
    end
    @(negedge clk);
    pwm = {NP{lvl}};
    @(posedge clk);
    if (late_val >= 0) begin
      #1;
      dt_val = CW'(late_val);
    end
    for (int i = 0; i < expg + 4; i++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        won  = lvl ? act_e(p) : act_o(p);
        lost = lvl ? act_o(p) : act_e(p);
        if (lost) loser_off = 1'b0;
        if (!seen[p]) begin
          if (won) seen[p] = 1'b1;
          else gap[p]++;
        end
      end
    end
    for (int p = 0; p < NP; p++) begin
      chk(seen[p] && gap[p] == expg, req, $sformatf("gap pair%0d lvl%0d", p, lvl), gap[p], expg);
    end
    chk(loser_off, "R4", "turn-off side inactive from first clock", int'(loser_off), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int vals [5];
    vals = '{1, 2, 3, 6, 63};

    // R1 reset state with mixed polarity
    pol_e = 2'b01;
    pol_o = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ch_e == pol_e, "R1", "even pins in reset", int'(ch_e), int'(pol_e));
    chk(ch_o == pol_o, "R1", "odd pins in reset", int'(ch_o), int'(pol_o));
    pol_e = '0;
    pol_o = '0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2 disabled by enable, then by zero length
    set_cfg(1'b0, 5, 0);
    edge_run(1'b1, 0, "R2", -1);
    @(negedge clk);
    chk(act_o(0) == !act_e(0), "R2", "odd is complement", int'(act_o(0)), int'(!act_e(0)));
    edge_run(1'b0, 0, "R2", -1);
    set_cfg(1'b1, 0, 2);
    edge_run(1'b1, 0, "R2", -1);
    edge_run(1'b0, 0, "R2", -1);

    // R8 pin levels with active-low outputs, deadtime off
    @(posedge clk); #1;
    pol_e = 2'b11;
    pol_o = 2'b11;
    pwm   = 2'b11;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(ch_e == 2'b00, "R8", "active-low even pins driven low", int'(ch_e), 0);
    chk(ch_o == 2'b11, "R8", "inactive odd pins high", int'(ch_o), 3);
    @(posedge clk); #1;
    pwm = 2'b00;
    repeat (2) @(posedge clk);

    // R3 R5 R8 R10 sweep of prescale codes and lengths
    for (int ps = 0; ps < 4; ps++) begin
      @(posedge clk); #1;
      pol_e = NP'(ps);
      pol_o = NP'(3 - ps);
      for (int k = 0; k < 5; k++) begin
        set_cfg(1'b1, vals[k], ps);
        edge_run(1'b1, exp_gap(1'b1, vals[k], ps), (ps >= 2) ? "R5" : "R3", -1);
        edge_run(1'b0, exp_gap(1'b1, vals[k], ps), "R10", -1);
      end
    end

    // R7 pulse shorter than the gap is swallowed
    begin
      bit even_seen;
      int og;
      bit oseen;
      even_seen = 1'b0;
      og = 0;
      oseen = 1'b0;
      set_cfg(1'b1, 4, 0);
      @(negedge clk);
      pwm = 2'b11;
      @(negedge clk);
      if (act_e(0)) even_seen = 1'b1;
      @(negedge clk);
      if (act_e(0)) even_seen = 1'b1;
      pwm = 2'b00;
      @(posedge clk);
      for (int i = 0; i < 9; i++) begin
        @(negedge clk);
        if (act_e(0)) even_seen = 1'b1;
        if (!oseen) begin
          if (act_o(0)) oseen = 1'b1;
          else og++;
        end
      end
      chk(!even_seen, "R7", "short pulse never reaches even", int'(even_seen), 0);
      chk(oseen && og == 4, "R7", "odd waits a fresh full gap", og, 4);
    end

    // R9 length change mid-gap applies to next gap only
    set_cfg(1'b1, 3, 0);
    edge_run(1'b1, 3, "R9", 10);
    edge_run(1'b0, 10, "R9", -1);

    // R10 pairs time independently
    begin
      set_cfg(1'b1, 5, 0);
      @(negedge clk);
      pwm = 2'b01;
      repeat (8) @(negedge clk);
      chk(act_e(0) == 1'b1, "R10", "pair0 even on", int'(act_e(0)), 1);
      chk(act_o(1) == 1'b1 && act_e(1) == 1'b0, "R10", "pair1 unaffected",
          int'({act_e(1), act_o(1)}), 1);
      pwm = 2'b00;
      repeat (8) @(negedge clk);
    end

    chk(overlap == 0, "R6", "cycles with both sides active", overlap, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule